// File: doc/BRIEF.md
# Cell Accumulator Readout and Clear Controller

This block sits beside a bank of multiply-accumulate cells and decides which cell result leaves the bank. A cell address picks one of the cell accumulators. The selected value is taken only on the first cycle of a selection. It is then either passed straight to the sum output or added into an output-stage accumulator. Keeping the address unchanged does not refresh the value. Changing the address starts a new selection.

The same address also names the cell to clear. Erase held low raises a clear strobe for that cell. When erase and reset are low together, every cell gets a clear strobe. Reset on its own clears only the output-stage state and leaves the cells alone. The upper and lower fields of the sum word each have their own active-low enable. A field that is disabled reads as zero and its drive flag drops, which stands in for a high-impedance pad.

Top module: `acc_readout_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, the output-stage register is cleared, so the sum output reads zero one clock later with both fields enabled.
- R2: In pass-through mode (add_mode_i = 0), a new selection shows the addressed cell's value on sum_o one clock after the address is applied.
- R3: While the address stays the same, sum_o does not change, even if the selected cell's value changes, in either mode.
- R4: An address that differs from the one on the previous edge, or the first address after reset, counts as a new selection and captures a fresh value.
- R5: In accumulate mode (add_mode_i = 1), each new selection adds the captured value into the output-stage register modulo 2^26, and sum_o shows the result one clock later.
- R6: With erase_n low and rst_n high, clr_o bit k (cell k at bit k) is the only bit set one clock later, where k is the address.
- R7: With erase_n and rst_n both low, all bits of clr_o are set one clock later.
- R8: With rst_n low and erase_n high, clr_o is all zero one clock later. The first selection after reset captures fresh, even at the address used before the reset.
- R9: hi_oe_n high forces sum_o[25:16] to zero and clears hi_drv_o. lo_oe_n high forces sum_o[15:0] to zero and clears lo_drv_o. Each enable affects only its own field, and each field responds in the same cycle its enable changes.
- R10: With erase_n high, clr_o is all zero one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of output-stage state; with erase_n low it clears all cells |
| addr_i | input | 3 | Cell address for readout and erase |
| erase_n | input | 1 | Active-low erase of the addressed cell |
| add_mode_i | input | 1 | 1 = add into output stage, 0 = pass through |
| hi_oe_n | input | 1 | Active-low enable of sum bits 25..16 |
| lo_oe_n | input | 1 | Active-low enable of sum bits 15..0 |
| cell_acc_i | input | 208 | Cell accumulator values, cell k at bits 26k+25..26k |
| sum_o | output | 26 | Sum word, disabled fields read zero |
| hi_drv_o | output | 1 | Upper field is driven |
| lo_drv_o | output | 1 | Lower field is driven |
| clr_o | output | 8 | Per-cell clear strobes, cell k at bit k |

## Verification
The assertions assume that the whole bank is reset before it is used. They are disabled while rst_n is low. As a result, clearing every cell under reset and reset's own clearing are checked only by the bench. The assertions also assume that every cell value is a defined 26-bit word and that the address always names an existing cell. To keep within these limits, the stimulus starts in reset and only ever drives addresses 0 to 7. It also sets all 208 bits of the cell input before each edge, using values chosen so that accumulate mode wraps past 2^26.

// File: rtl/acc_readout_pkg.sv
package acc_readout_pkg;
   parameter int unsigned DEF_CELLS = 8;
   parameter int unsigned DEF_ACC_W = 26;
   parameter int unsigned DEF_HI_W  = 10;

   typedef enum logic {
      STAGE_PASS = 1'b0,
      STAGE_ADD  = 1'b1
   } stage_mode_e;
endpackage

// File: rtl/acc_cell_select.sv
module acc_cell_select #(
   parameter int unsigned N_CELLS = 8,
   parameter int unsigned ACC_W   = 26,
   localparam int unsigned ADDR_W = $clog2(N_CELLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [N_CELLS*ACC_W-1:0] cells_i,
   output logic                     new_sel_o,
   output logic [ACC_W-1:0]         sel_val_o
);
   logic [ACC_W-1:0]  cell_arr [N_CELLS];
   logic [ADDR_W-1:0] addr_q;
   logic              live_q;

   generate
      for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_unpack
         assign cell_arr[gi] = cells_i[gi*ACC_W +: ACC_W];
      end
   endgenerate

   always_comb begin
      sel_val_o = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         if (addr_i == ADDR_W'(i)) sel_val_o = cell_arr[i];
      end
   end

   // a selection is new when nothing is live or the address moved
   assign new_sel_o = !live_q || (addr_i != addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         addr_q <= '0;
      end else begin
         live_q <= 1'b1;
         addr_q <= addr_i;
      end
   end
endmodule

// File: rtl/acc_out_stage.sv
module acc_out_stage
   import acc_readout_pkg::*;
#(
   parameter int unsigned ACC_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             new_sel_i,
   input  stage_mode_e      mode_i,
   input  logic [ACC_W-1:0] sel_val_i,
   output logic [ACC_W-1:0] stage_o
);
   logic [ACC_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (new_sel_i) begin
         if (mode_i == STAGE_ADD) stage_q <= stage_q + sel_val_i;
         else                     stage_q <= sel_val_i;
      end
   end

   assign stage_o = stage_q;

   AST_HOLD_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      !new_sel_i |=> $stable(stage_o)); // R3
   AST_PASS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (new_sel_i && mode_i == STAGE_PASS) |=> stage_o == $past(sel_val_i)); // R2
   AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (new_sel_i && mode_i == STAGE_ADD) |=>
         stage_o == ACC_W'($past(stage_o) + $past(sel_val_i))); // R5
endmodule

// File: rtl/acc_erase_ctl.sv
module acc_erase_ctl #(
   parameter int unsigned N_CELLS = 8,
   localparam int unsigned ADDR_W = $clog2(N_CELLS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               erase_n,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [N_CELLS-1:0] clr_o
);
   generate
      for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_strobe
         logic clr_q;
         always_ff @(posedge clk) begin
            clr_q <= !erase_n && (!rst_n || addr_i == ADDR_W'(gi));
         end
         assign clr_o[gi] = clr_q;
      end
   endgenerate

   AST_NO_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_n |=> clr_o == '0); // R10
   AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_n |=> $countones(clr_o) == 1); // R6
endmodule

// File: rtl/acc_field_drive.sv
module acc_field_drive #(
   parameter int unsigned ACC_W = 26,
   parameter int unsigned HI_W  = 10,
   localparam int unsigned LO_W = ACC_W - HI_W
) (
   input  logic [ACC_W-1:0] stage_i,
   input  logic             hi_oe_n,
   input  logic             lo_oe_n,
   output logic [ACC_W-1:0] sum_o,
   output logic             hi_drv_o,
   output logic             lo_drv_o
);
   logic [HI_W-1:0] hi_f;
   logic [LO_W-1:0] lo_f;

   assign hi_f     = hi_oe_n ? {HI_W{1'b0}} : stage_i[ACC_W-1:LO_W];
   assign lo_f     = lo_oe_n ? {LO_W{1'b0}} : stage_i[LO_W-1:0];
   assign sum_o    = {hi_f, lo_f};
   assign hi_drv_o = !hi_oe_n;
   assign lo_drv_o = !lo_oe_n;
endmodule

// File: rtl/acc_readout_ctl.sv
module acc_readout_ctl
   import acc_readout_pkg::*;
#(
   parameter int unsigned N_CELLS = DEF_CELLS,
   parameter int unsigned ACC_W   = DEF_ACC_W,
   parameter int unsigned HI_W    = DEF_HI_W,
   localparam int unsigned ADDR_W = $clog2(N_CELLS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     erase_n,
   input  logic                     add_mode_i,
   input  logic                     hi_oe_n,
   input  logic                     lo_oe_n,
   input  logic [N_CELLS*ACC_W-1:0] cell_acc_i,
   output logic [ACC_W-1:0]         sum_o,
   output logic                     hi_drv_o,
   output logic                     lo_drv_o,
   output logic [N_CELLS-1:0]       clr_o
);
   generate
      if (N_CELLS < 2) begin : g_bad_cells
         $error("acc_readout_ctl: N_CELLS must be at least 2");
      end
      if (HI_W == 0 || HI_W >= ACC_W) begin : g_bad_split
         $error("acc_readout_ctl: HI_W must lie between 1 and ACC_W-1");
      end
   endgenerate

   logic             new_sel;
   logic [ACC_W-1:0] sel_val;
   logic [ACC_W-1:0] stage_val;

   acc_cell_select #(.N_CELLS(N_CELLS), .ACC_W(ACC_W)) u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .cells_i   (cell_acc_i),
      .new_sel_o (new_sel),
      .sel_val_o (sel_val)
   );

   acc_out_stage #(.ACC_W(ACC_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .new_sel_i (new_sel),
      .mode_i    (stage_mode_e'(add_mode_i)),
      .sel_val_i (sel_val),
      .stage_o   (stage_val)
   );

   acc_erase_ctl #(.N_CELLS(N_CELLS)) u_erase (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase_n (erase_n),
      .addr_i  (addr_i),
      .clr_o   (clr_o)
   );

   acc_field_drive #(.ACC_W(ACC_W), .HI_W(HI_W)) u_drive (
      .stage_i  (stage_val),
      .hi_oe_n  (hi_oe_n),
      .lo_oe_n  (lo_oe_n),
      .sum_o    (sum_o),
      .hi_drv_o (hi_drv_o),
      .lo_drv_o (lo_drv_o)
   );

   AST_ADDR_CHANGE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n) && addr_i != $past(addr_i)) |-> new_sel); // R4
endmodule

// File: tb/acc_readout_ctl_tb.sv
module acc_readout_ctl_tb;
   localparam int NC = 8;
   localparam int AW = 26;
   localparam logic [AW-1:0] MASK = {AW{1'b1}};

   logic             clk = 1'b0;
   logic             rst_n;
   logic [2:0]       addr_i;
   logic             erase_n;
   logic             add_mode_i;
   logic             hi_oe_n;
   logic             lo_oe_n;
   logic [NC*AW-1:0] cell_acc_i;
   logic [AW-1:0]    sum_o;
   logic             hi_drv_o;
   logic             lo_drv_o;
   logic [NC-1:0]    clr_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [AW-1:0] cells [NC];
   logic [AW-1:0] model;

   always #2.5 clk = ~clk;

   acc_readout_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .erase_n(erase_n),
      .add_mode_i(add_mode_i), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n),
      .cell_acc_i(cell_acc_i), .sum_o(sum_o), .hi_drv_o(hi_drv_o),
      .lo_drv_o(lo_drv_o), .clr_o(clr_o)
   );

   function automatic logic [AW-1:0] pat(int a, int k);
      logic [31:0] v;
      v = 32'h03FF_0000 + 32'(a) * 32'h0135_79BD + 32'(k) * 32'h0024_6801;
      return v[AW-1:0];
   endfunction

   task automatic load_cells(int k);
      for (int i = 0; i < NC; i++) begin
         cells[i] = pat(i, k);
         cell_acc_i[i*AW +: AW] = cells[i];
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; erase_n = 1'b1; addr_i = 3'd0; add_mode_i = 1'b0;
      hi_oe_n = 1'b0; lo_oe_n = 1'b0;
      load_cells(0);
      tick(); tick();
      check("R1 sum after reset", 32'(sum_o), 32'd0);
      check("R8 no clear under reset alone", 32'(clr_o), 32'd0);

      // R2 / R4: pass-through sweep, every address change captures fresh
      rst_n = 1'b1;
      for (int a = 0; a < NC; a++) begin
         addr_i = 3'(a);
         load_cells(a + 1);
         tick();
         check("R2 pass capture", 32'(sum_o), 32'(cells[a]));
      end
      model = cells[7];

      // R3: hold address 7 while its cell keeps changing
      for (int k = 0; k < 3; k++) begin
         load_cells(20 + k);
         tick();
         check("R3 hold in pass mode", 32'(sum_o), 32'(model));
      end

      // R4: step away and back yields a fresh capture
      addr_i = 3'd2; load_cells(30); tick();
      check("R4 new address", 32'(sum_o), 32'(cells[2]));
      addr_i = 3'd7; load_cells(31); tick();
      check("R4 return address", 32'(sum_o), 32'(cells[7]));
      model = cells[7];

      // R5: accumulate sweep with wraparound
      add_mode_i = 1'b1;
      for (int a = 0; a < NC; a++) begin
         addr_i = 3'(a);
         load_cells(40 + a);
         model = (model + cells[a]) & MASK;
         tick();
         check("R5 accumulate", 32'(sum_o), 32'(model));
      end
      for (int k = 0; k < 2; k++) begin
         load_cells(60 + k);
         tick();
         check("R3 hold in accumulate mode", 32'(sum_o), 32'(model));
      end

      // R6: single-cell erase for every address
      add_mode_i = 1'b0;
      erase_n = 1'b0;
      for (int a = 0; a < NC; a++) begin
         addr_i = 3'(a);
         tick();
         check("R6 single erase", 32'(clr_o), 32'(1) << a);
      end
      erase_n = 1'b1;
      tick();
      check("R10 no erase", 32'(clr_o), 32'd0);

      // R7: erase all under reset
      erase_n = 1'b0; rst_n = 1'b0;
      tick();
      check("R7 erase all", 32'(clr_o), 32'hFF);
      check("R1 sum cleared", 32'(sum_o), 32'd0);
      erase_n = 1'b1;
      tick();
      check("R8 reset alone no clear", 32'(clr_o), 32'd0);
      check("R8 stage cleared", 32'(sum_o), 32'd0);

      // R8: same address after reset still captures fresh
      rst_n = 1'b1;
      load_cells(70);
      tick();
      check("R8 fresh after reset", 32'(sum_o), 32'(cells[7]));
      model = cells[7];

      // R9: every enable combination
      for (int m = 0; m < 4; m++) begin
         hi_oe_n = m[1]; lo_oe_n = m[0];
         #1;
         check("R9 upper field", 32'(sum_o[25:16]), m[1] ? 32'd0 : 32'(model[25:16]));
         check("R9 lower field", 32'(sum_o[15:0]),  m[0] ? 32'd0 : 32'(model[15:0]));
         check("R9 drive flags", {30'd0, hi_drv_o, lo_drv_o}, {30'd0, ~m[1], ~m[0]});
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule